// File: doc/BRIEF.md
# Indexed Global Configuration Register Block

This block holds the chip-wide configuration registers of a peripheral controller. The registers sit behind a two-port window. A write to the index port stores an 8-bit register address. Later accesses through the data port then reach the register at that address. Reads are combinational and return the register the stored index points at.

Only the logical-device select register and the soft-reset trigger hold or cause state. The identification registers return fixed values. Every other address from 0x00 to 0xFF reads as zero and ignores writes.

Access is allowed only while the configuration-mode input is high. The sequence that raises this input lies outside the block. A soft reset is started by writing 1 to bit 0 of the control register. That write produces a one-cycle pulse and returns the logical-device number to zero.

Top module: `glob_cfg_regs`

## Requirements
- R1: When `cfg_mode` is high, a write with `port_sel`=0 stores all 8 bits of `wdata` as the index. A read with `port_sel`=0 returns the stored index.
- R2: Data-port accesses (`port_sel`=1) decode all 8 index bits, so there is no aliasing. Any index other than 0x07, 0x20 and 0x21 reads as 0x00 and ignores writes. This covers 0x87, 0xA0 and every other address whose low bits match a live register.
- R3: When `cfg_mode` is low, writes on both ports have no effect and `rdata` is 0x00. The stored index and the logical-device number keep their values across mode changes.
- R4: Index 0x07 is readable and writable. Its value drives `ldev_sel`, which takes a written value at the clock edge of the write.
- R5: A data write to index 0x02 with `wdata[0]`=1 sets `soft_rst_pulse` high for exactly one cycle, starting at the edge of the write. A write with bit 0 clear gives no pulse. Index 0x02 always reads 0x00.
- R6: A soft reset clears the logical-device number to 0x00 at the same edge at which the pulse rises.
- R7: Index 0x20 reads `DEV_ID` (default 0x47), and writes to it are ignored.
- R8: Index 0x21 reads `DEV_REV` (default 0x00), and writes to it are ignored.
- R9: While `rst_n` is low, the index, the logical-device number and `soft_rst_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_mode | input | 1 | Configuration mode active level |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected port (combinational) |
| soft_rst_pulse | output | 1 | One-cycle soft-reset pulse |
| ldev_sel | output | 8 | Current logical device number |

## Verification
The assertions assume that `cfg_mode`, `port_sel`, `wr_en` and `wdata` are synchronous to `clk` and settle before each rising edge. They also assume a soft-reset pulse comes only from a qualifying data write. The bench drives every input on the falling edge and holds it through the next rising edge. It samples the combinational read data mid-cycle and samples registered effects on the falling edge after the write.

// File: rtl/glob_cfg_regs.sv
module glob_cfg_regs #(
  parameter int          W       = 8,
  parameter logic [7:0]  DEV_ID  = 8'h47,
  parameter logic [7:0]  DEV_REV = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_mode,
  input  logic         port_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         soft_rst_pulse,
  output logic [W-1:0] ldev_sel
);

  localparam logic [W-1:0] A_CTRL = W'(8'h02);
  localparam logic [W-1:0] A_LDEV = W'(8'h07);
  localparam logic [W-1:0] A_ID   = W'(8'h20);
  localparam logic [W-1:0] A_REV  = W'(8'h21);

  logic [W-1:0] idx_q;
  logic [W-1:0] ldev_q;
  logic         pulse_q;

  wire idx_wr  = cfg_mode && wr_en && !port_sel;
  wire data_wr = cfg_mode && wr_en &&  port_sel;
  wire srst_go = data_wr && (idx_q == A_CTRL) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ldev_q <= '0;
    else if (srst_go)                        ldev_q <= '0;
    else if (data_wr && idx_q == A_LDEV)     ldev_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= srst_go;
  end

  always_comb begin
    rdata = '0;
    if (cfg_mode) begin
      if (!port_sel) rdata = idx_q;
      else begin
        case (idx_q)
          A_LDEV:  rdata = ldev_q;
          A_ID:    rdata = W'(DEV_ID);
          A_REV:   rdata = W'(DEV_REV);
          default: rdata = '0;
        endcase
      end
    end
  end

  assign soft_rst_pulse = pulse_q;
  assign ldev_sel       = ldev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse); // R5
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst_pulse) |-> $past(cfg_mode && wr_en && port_sel && wdata[0])); // R5
  AST_LDEV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (ldev_sel == '0)); // R6
  AST_NOCFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(ldev_sel) || soft_rst_pulse)); // R3
  AST_NOCFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (rdata == '0)); // R3
  AST_NOCFG_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(idx_q)); // R3
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && port_sel && idx_q == A_ID) |-> (rdata == W'(DEV_ID))); // R7

endmodule

// File: tb/test_glob_cfg_regs.sv
module test_glob_cfg_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_mode = 0;
  logic       port_sel = 0;
  logic       wr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       soft_rst_pulse;
  logic [7:0] ldev_sel;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  glob_cfg_regs i_glob_cfg_regs (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .port_sel(port_sel),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .soft_rst_pulse(soft_rst_pulse), .ldev_sel(ldev_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    port_sel = sel; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    port_sel = sel; wr_en = 0;
    #2 v = rdata;
  endtask

  function automatic logic [7:0] expect_at(input logic [7:0] a, input logic [7:0] ld);
    if (a == 8'h07) return ld;
    if (a == 8'h20) return 8'h47;
    return 8'h00;
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] ld_model;
    repeat (3) @(negedge clk);
    chk("R9 ldev in reset", ldev_sel, 8'h00);
    chk("R9 pulse in reset", {7'd0, soft_rst_pulse}, 8'h00);
    rst_n = 1;
    cfg_mode = 1;
    rd(0, v); chk("R9 index after reset", v, 8'h00);

    // R1 index latch, every value
    for (int a = 0; a < 256; a++) begin
      wr(0, 8'(a)); rd(0, v); chk("R1 index readback", v, 8'(a));
    end

    // R2 R4 R7 R8: write pattern to every address except the control reg
    ld_model = 8'h00;
    for (int a = 0; a < 256; a++) begin
      if (a != 2) begin
        wr(0, 8'(a)); wr(1, 8'(a) ^ 8'h5A);
        if (a == 7) begin
          ld_model = 8'(a) ^ 8'h5A;
          chk("R4 ldev_sel follows write", ldev_sel, ld_model);
        end
      end
    end
    for (int a = 0; a < 256; a++) begin
      wr(0, 8'(a)); rd(1, v);
      chk(a == 8'h20 ? "R7 id read" : a == 8'h21 ? "R8 rev read" :
          a == 7 ? "R4 ldev read" : "R2 unassigned zero", v, expect_at(8'(a), ld_model));
    end

    // R5 bit0 clear gives no pulse, control reads zero
    wr(0, 8'h02); wr(1, 8'hFE);
    chk("R5 no pulse on bit0=0", {7'd0, soft_rst_pulse}, 8'h00);
    chk("R5 ldev kept", ldev_sel, ld_model);
    rd(1, v); chk("R5 control reads zero", v, 8'h00);

    // R5 R6 soft reset
    wr(0, 8'h02);
    @(negedge clk); port_sel = 1; wdata = 8'h01; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk("R5 pulse high", {7'd0, soft_rst_pulse}, 8'h01);
    chk("R6 ldev cleared", ldev_sel, 8'h00);
    @(negedge clk);
    chk("R5 pulse one cycle", {7'd0, soft_rst_pulse}, 8'h00);

    // R3 mode off
    wr(0, 8'h07); wr(1, 8'h33);
    chk("R4 ldev set", ldev_sel, 8'h33);
    cfg_mode = 0;
    wr(1, 8'h99); wr(0, 8'h02); wr(1, 8'h01);
    chk("R3 no pulse outside mode", {7'd0, soft_rst_pulse}, 8'h00);
    chk("R3 ldev unchanged", ldev_sel, 8'h33);
    rd(0, v); chk("R3 index port reads zero", v, 8'h00);
    rd(1, v); chk("R3 data port reads zero", v, 8'h00);
    cfg_mode = 1;
    rd(0, v); chk("R3 index kept", v, 8'h07);
    rd(1, v); chk("R3 ldev read after mode", v, 8'h33);

    // R9 hardware reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R9 ldev cleared by reset", ldev_sel, 8'h00);
    rst_n = 1;
    rd(0, v); chk("R9 index cleared by reset", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule